// File: doc/BRIEF.md
# Serial Character Receiver

This block takes characters off one serial data line and turns each into a parallel word. It runs in one of two modes. In oversampled mode it times itself from a clock enable that pulses sixteen times per bit period. It looks for a falling edge on the line, checks that the line stays low through the first half of the start bit, and then samples each later bit at its nominal centre. In clocked mode the same frame is sampled on rising edges of an external bit clock, one bit per edge. The block does not generate a baud rate and holds only one received word.

A frame is one start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one stop bit. The finished word goes into a single holding stage, which is offered on a valid/ready output. The consumer takes the word in any cycle where `out_valid` and `out_ready` are both high. The block cannot be stalled. If the consumer falls behind, the next completed frame replaces the held word and raises an overrun flag. The parity, framing and overrun flags travel with the word that is held.

Top module: `serial_char_rx`

## Requirements
- R1: After reset the receiver is idle and searching for a start bit, and `out_valid`, `out_perr`, `out_ferr`, `out_ovr` and `out_data` are all zero.
- R2: In oversampled mode (`sync_mode`=0), a high-to-low change on `rxd` starts a start-bit check. The line is sampled on each of the next eight `tick16` pulses. If any of these samples is high, the frame is dropped and the search for a new falling edge resumes, so a low pulse shorter than eight ticks produces no word.
- R3: In clocked mode (`sync_mode`=1), after a falling edge the start bit is sampled once, at the next rising edge of `bclk`. Each later bit is sampled at one rising edge of `bclk`.
- R4: Data bits arrive least significant bit first. `len_sel` gives the data length: 0 means 5 bits, 1 means 6, 2 means 7 and 3 means 8. In oversampled mode each bit is sampled 16 ticks after the previous sample.
- R5: For words shorter than 8 bits, the unused upper bits of `out_data` are zero.
- R6: When `par_en`=1, a parity bit follows the data. With `par_odd`=0 the data bits plus the parity bit must hold an even number of ones; with `par_odd`=1 they must hold an odd number. A mismatch sets `out_perr` together with the word. With `par_en`=0, `out_perr` stays 0.
- R7: A stop bit sampled low sets `out_ferr`. The word is still delivered.
- R8: A completed frame loads the holding stage and sets `out_valid`. A cycle with `out_valid` and `out_ready` both high takes the word and clears `out_valid` and `out_ovr`. While the word is held, `out_data` stays unchanged.
- R9: If a frame completes while `out_valid` is high and the word is not being taken in that cycle, `out_data` is replaced by the new word and `out_ovr` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit period |
| sync_mode | input | 1 | 0: oversampled start search, 1: sample on `bclk` rising edges |
| bclk | input | 1 | External bit clock for clocked mode (synchronized inside) |
| rxd | input | 1 | Serial data line, idle high (synchronized inside) |
| len_sel | input | 2 | Data length select, 0..3 gives 5..8 bits |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| out_valid | output | 1 | Holding stage contains a word |
| out_ready | input | 1 | Consumer takes the word when `out_valid` is high |
| out_data | output | 8 | Received word, right aligned and zero filled |
| out_perr | output | 1 | Parity error for the held word |
| out_ferr | output | 1 | Framing error for the held word |
| out_ovr | output | 1 | A word was overwritten before it was taken |

## Verification
The in-line assertions check three things on every cycle. A held word stays unchanged until it is taken. The overrun flag is never set without a held word. The unused upper data bits are zero whenever a word is delivered. Two more assertions watch start-bit handling: a high start sample in oversampled mode sends the receiver back to idle, and a low start sample at a `bclk` edge moves it to data sampling. Only the bench's frames can show the rest: that bits are put together in the right order and at the right times, that parity is computed across the several lengths, that framing and overrun are reported with the right word, and that a short glitch leaves the receiver able to take the next frame.

// File: rtl/serial_rx_pkg.sv
`timescale 1ns/1ps
package serial_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/srx_sync.sv
`timescale 1ns/1ps
module srx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RST_VAL}};
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/srx_core.sv
`timescale 1ns/1ps
module srx_core
  import serial_rx_pkg::*;
#(
  parameter int OSR  = 16,
  parameter int DMAX = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            bclk_rise,
  input  logic            line,
  input  logic            sync_mode,
  input  logic [1:0]      len_sel,
  input  logic            par_en,
  input  logic            par_odd,
  output logic            done,
  output logic [DMAX-1:0] done_data,
  output logic            done_perr,
  output logic            done_ferr
);
  localparam int TW   = $clog2(OSR);
  localparam int HALF = OSR / 2;
  localparam int BW   = $clog2(DMAX);
  localparam int MINB = DMAX - 3;

  rx_state_e      st;
  logic [TW-1:0]  tcnt;
  logic [BW-1:0]  bcnt;
  logic [DMAX-1:0] shreg;
  logic           par_acc, perr_q, line_q;
  logic           fall, step, center_hit;
  logic [BW:0]    nbits, shamt;
  logic [BW-1:0]  last_idx;
  logic [TW-1:0]  tcnt_adv;

  assign nbits      = (BW+1)'(MINB) + (BW+1)'(len_sel);
  assign shamt      = (BW+1)'(DMAX) - nbits;
  assign last_idx   = BW'(nbits - 1'b1);
  assign fall       = line_q & ~line;
  assign step       = sync_mode ? bclk_rise : tick;
  assign center_hit = sync_mode ? bclk_rise : (tick && tcnt == TW'(OSR-1));
  assign tcnt_adv   = center_hit ? '0 : tcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      tcnt      <= '0;
      bcnt      <= '0;
      shreg     <= '0;
      par_acc   <= 1'b0;
      perr_q    <= 1'b0;
      line_q    <= 1'b1;
      done      <= 1'b0;
      done_data <= '0;
      done_perr <= 1'b0;
      done_ferr <= 1'b0;
    end else begin
      line_q <= line;
      done   <= 1'b0;
      if (st inside {ST_DATA, ST_PARITY, ST_STOP} && tick && !sync_mode)
        tcnt <= tcnt_adv;
      case (st)
        ST_IDLE: if (fall) begin
          st      <= ST_START;
          tcnt    <= '0;
          bcnt    <= '0;
          shreg   <= '0;
          par_acc <= 1'b0;
          perr_q  <= 1'b0;
        end
        ST_START: if (step) begin
          if (line) st <= ST_IDLE;              // start bit rejected
          else if (sync_mode || tcnt == TW'(HALF-1)) begin
            st   <= ST_DATA;
            tcnt <= '0;
          end else tcnt <= tcnt + 1'b1;
        end
        ST_DATA: if (center_hit) begin
          shreg   <= {line, shreg[DMAX-1:1]};   // lsb first
          par_acc <= par_acc ^ line;
          bcnt    <= bcnt + 1'b1;
          if (bcnt == last_idx) st <= par_en ? ST_PARITY : ST_STOP;
        end
        ST_PARITY: if (center_hit) begin
          perr_q <= (par_acc ^ line) != par_odd;
          st     <= ST_STOP;
        end
        ST_STOP: if (center_hit) begin
          done      <= 1'b1;
          done_data <= shreg >> shamt;
          done_perr <= par_en & perr_q;
          done_ferr <= ~line;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_START_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START && !sync_mode && tick && line) |=> (st == ST_IDLE)); // R2
  AST_SYNC_START: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START && sync_mode && bclk_rise && !line) |=> (st == ST_DATA)); // R3
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((done_data >> nbits) == '0)); // R5
endmodule

// File: rtl/srx_hold.sv
`timescale 1ns/1ps
module srx_hold #(
  parameter int DMAX = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [DMAX-1:0] ld_data,
  input  logic            ld_perr,
  input  logic            ld_ferr,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [DMAX-1:0] out_data,
  output logic            out_perr,
  output logic            out_ferr,
  output logic            out_ovr
);
  logic take;
  assign take = out_valid & out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_perr  <= 1'b0;
      out_ferr  <= 1'b0;
      out_ovr   <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= ld_data;
      out_perr  <= ld_perr;
      out_ferr  <= ld_ferr;
      out_ovr   <= out_valid & ~out_ready;
    end else if (take) begin
      out_valid <= 1'b0;
      out_ovr   <= 1'b0;
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !load) |=> out_valid); // R8
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !load) |=> $stable(out_data)); // R8
  AST_OVR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_ovr |-> out_valid); // R9
endmodule

// File: rtl/serial_char_rx.sv
`timescale 1ns/1ps
module serial_char_rx #(
  parameter int OSR         = 16,
  parameter int DMAX        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick16,
  input  logic            sync_mode,
  input  logic            bclk,
  input  logic            rxd,
  input  logic [1:0]      len_sel,
  input  logic            par_en,
  input  logic            par_odd,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [DMAX-1:0] out_data,
  output logic            out_perr,
  output logic            out_ferr,
  output logic            out_ovr
);
  logic line_s, bclk_s, bclk_q, bclk_rise;
  logic done, done_perr, done_ferr;
  logic [DMAX-1:0] done_data;

  srx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_line_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(line_s));
  srx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_bclk_sync (
    .clk(clk), .rst_n(rst_n), .d(bclk), .q(bclk_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_q <= 1'b0;
    else        bclk_q <= bclk_s;
  end
  assign bclk_rise = bclk_s & ~bclk_q;

  srx_core #(.OSR(OSR), .DMAX(DMAX)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .bclk_rise(bclk_rise),
    .line(line_s), .sync_mode(sync_mode), .len_sel(len_sel),
    .par_en(par_en), .par_odd(par_odd), .done(done),
    .done_data(done_data), .done_perr(done_perr), .done_ferr(done_ferr));

  srx_hold #(.DMAX(DMAX)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(done), .ld_data(done_data),
    .ld_perr(done_perr), .ld_ferr(done_ferr), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_perr(out_perr),
    .out_ferr(out_ferr), .out_ovr(out_ovr));
endmodule

// File: tb/serial_char_rx_bench.sv
`timescale 1ns/1ps
module serial_char_rx_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, sync_mode = 1'b0;
  logic bclk = 1'b0, rxd = 1'b1, par_en = 1'b0, par_odd = 1'b0, out_ready = 1'b0;
  logic [1:0] len_sel = 2'd3;
  logic out_valid, out_perr, out_ferr, out_ovr;
  logic [7:0] out_data;
  int n_chk = 0, n_fail = 0;

  serial_char_rx u_serial_char_rx (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .sync_mode(sync_mode),
    .bclk(bclk), .rxd(rxd), .len_sel(len_sel), .par_en(par_en),
    .par_odd(par_odd), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_perr(out_perr), .out_ferr(out_ferr),
    .out_ovr(out_ovr));

  always #10 clk = ~clk;   // 50 MHz

  // tick16 every 4 clocks: 64 clocks per bit period
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      tick16 = (cnt == 3);
      cnt = (cnt + 1) % 4;
    end
  end

  // fields: len_sel[23:22] par_en[21] par_odd[20] bad_par[19] bad_stop[18]
  //         sent[15:8] expected[7:0]
  localparam logic [23:0] VEC [8] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 8'hA5, 8'hA5},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 8'hFF, 8'h1F},
    {2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 8'h53, 8'h53},
    {2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 8'h2C, 8'h2C},
    {2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 8'h3C, 8'h3C},
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 8'h81, 8'h81},
    {2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 8'h00, 8'h00},
    {2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 8'hD5, 8'h15}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_async(logic b);
    @(negedge clk) rxd = b;
    repeat (63) @(negedge clk);
  endtask

  task automatic bit_sync(logic b);
    @(negedge clk) begin bclk = 1'b0; rxd = b; end
    repeat (3) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(logic clocked, int nb, logic [7:0] d, logic pe, logic po,
                      logic badp, logic bads);
    logic pb;
    pb = po;
    for (int i = 0; i < nb; i++) pb ^= d[i];
    if (badp) pb = ~pb;
    len_sel = 2'(nb - 5); par_en = pe; par_odd = po; sync_mode = clocked;
    if (clocked) begin
      bit_sync(1'b1); bit_sync(1'b1);
      bit_sync(1'b0);
      for (int i = 0; i < nb; i++) bit_sync(d[i]);
      if (pe) bit_sync(pb);
      bit_sync(~bads);
      bit_sync(1'b1); bit_sync(1'b1);
    end else begin
      bit_async(1'b0);
      for (int i = 0; i < nb; i++) bit_async(d[i]);
      if (pe) bit_async(pb);
      bit_async(~bads);
      bit_async(1'b1); bit_async(1'b1);
    end
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 3000 && !out_valid; i++) @(negedge clk);
  endtask

  task automatic take_word();
    @(negedge clk) out_ready = 1'b1;
    @(negedge clk) out_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 flags", {29'd0, out_perr, out_ferr, out_ovr}, 0);
    chk("R1 out_data", 32'(out_data), 0);

    // table walk: R4 R5 R6 R7 R8
    foreach (VEC[k]) begin
      logic [23:0] v;
      v = VEC[k];
      send(1'b0, int'(v[23:22]) + 5, v[15:8], v[21], v[20], v[19], v[18]);
      wait_valid();
      chk($sformatf("R8 vec%0d valid", k), 32'(out_valid), 1);
      chk($sformatf("R4/R5 vec%0d data", k), 32'(out_data), 32'(v[7:0]));
      chk($sformatf("R6 vec%0d perr", k), 32'(out_perr), 32'(v[21] & v[19]));
      chk($sformatf("R7 vec%0d ferr", k), 32'(out_ferr), 32'(v[18]));
      chk($sformatf("R9 vec%0d ovr", k), 32'(out_ovr), 0);
      take_word();
      chk($sformatf("R8 vec%0d taken", k), 32'(out_valid), 0);
    end

    // R2 start glitches shorter than eight ticks are rejected
    sync_mode = 1'b0; len_sel = 2'd3; par_en = 1'b0;
    @(negedge clk) rxd = 1'b0;
    repeat (12) @(negedge clk);
    rxd = 1'b1;
    repeat (200) @(negedge clk);
    rxd = 1'b0;
    repeat (20) @(negedge clk);
    rxd = 1'b1;
    repeat (300) @(negedge clk);
    chk("R2 glitch gives no word", 32'(out_valid), 0);
    send(1'b0, 8, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0);
    wait_valid();
    chk("R2 search resumes", 32'(out_data), 32'h5A);
    take_word();

    // R9 overrun
    send(1'b0, 8, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0);
    send(1'b0, 8, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0);
    wait_valid();
    chk("R9 overrun flag", 32'(out_ovr), 1);
    chk("R9 data replaced", 32'(out_data), 32'h22);
    take_word();
    chk("R8 take clears ovr", {30'd0, out_valid, out_ovr}, 0);

    // R3 clocked mode
    send(1'b1, 8, 8'h6B, 1'b1, 1'b0, 1'b0, 1'b0);
    wait_valid();
    chk("R3 clocked data", 32'(out_data), 32'h6B);
    chk("R3 clocked flags", {30'd0, out_perr, out_ferr}, 0);
    take_word();
    send(1'b1, 6, 8'h15, 1'b0, 1'b0, 1'b0, 1'b1);
    wait_valid();
    chk("R3 clocked short data", 32'(out_data), 32'h15);
    chk("R7 clocked ferr", 32'(out_ferr), 1);
    take_word();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule